// File: doc/BRIEF.md
# Fixed-Frame Pulse-Width Modulator

This block turns an unsigned duty word into a single-bit pulse train whose frame is fixed. Each frame is divided into 2^DUTY_W equal slots (256 with the default 8-bit word). The output is high for as many slots as the duty word says, starting at the beginning of the frame, and low for the remaining slots. With a 200 MHz clock and 15625 clock cycles per slot, one frame lasts 20 ms and one slot lasts 20/256 ms.

A prescaler counts clock cycles within a slot. A slot counter advances once per slot and wraps from the last slot back to slot 0. A compare stage captures the duty word at the first cycle of every frame and drives a registered output. Because the largest duty word covers one slot less than a whole frame, the output always goes low for at least the final slot. The slot length is a parameter, so the same design serves any clock frequency, and a short slot can be used in simulation.

Top module: `pwm_frame_gen`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `pwm_o` is 0 after that edge, and the prescaler, slot counter and captured duty are cleared.
- R2: A frame is exactly 2^DUTY_W × TICKS_PER_SLOT clock cycles. Each slot lasts TICKS_PER_SLOT cycles, and the slot counter wraps from its last value to 0.
- R3: Take cycle index n, counted from 0 at the first edge where `rst_i` is low. After edge n, `pwm_o` is 1 exactly when (floor(n / TICKS_PER_SLOT) mod 2^DUTY_W) < D, where D is the duty captured for that frame. The output is high for D slots at the start of the frame and low for the rest.
- R4: With a duty of 0, `pwm_o` stays 0 for the whole frame.
- R5: With the maximum duty (all ones, 255 by default), `pwm_o` is high for 255 slots and low for the last slot. It is never high for a whole frame.
- R6: `duty_i` is sampled only at the edge that starts a frame, where n mod frame length = 0. Any change in the middle of a frame does not affect `pwm_o` until the next frame.
- R7: When reset is released, a new frame begins at slot 0 on the first edge with `rst_i` low, and the duty present at that edge is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| duty_i | input | DUTY_W | Unsigned duty word, in slots of high time per frame |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The duty word is tried at the directed values 0, 1, 128 and 255. A duty of 0 shows that the output never rises. A duty of 1 shows that exactly one slot is high. A duty of 255 shows that the last slot is low, so the output is never continuously high. Random frames and random changes of the duty word on every cycle separate a design that samples only at frame start from one that tracks the input directly. A reset in the middle of a frame shows whether the prescaler and slot counter restart together.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned DEFAULT_DUTY_W = 8;
    localparam int unsigned DEFAULT_TICKS  = 15625;

    // clock cycles per slot for a given clock (kHz), frame length (us) and slot count
    function automatic int unsigned slot_ticks(longint unsigned clk_khz,
                                               longint unsigned frame_us,
                                               longint unsigned slots);
        longint unsigned t;
        t = (clk_khz * frame_us) / (64'd1000 * slots);
        return (t == 0) ? 1 : int'(t);
    endfunction
endpackage

// File: rtl/pwm_slot_prescaler.sv
module pwm_slot_prescaler #(
    parameter int unsigned TICKS_PER_SLOT = pwm_pkg::DEFAULT_TICKS
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic slot_begin_o,
    output logic slot_end_o,
    output logic [((TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1)-1:0] tick_o
);
    localparam int unsigned CW = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SLOT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        slot_end_o   = (s_q.cnt == LAST);
        slot_begin_o = (s_q.cnt == '0);
        if (slot_end_o) s_d.cnt = '0;
        else            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign tick_o = s_q.cnt;
endmodule

// File: rtl/pwm_slot_counter.sv
module pwm_slot_counter #(
    parameter int unsigned DUTY_W = pwm_pkg::DEFAULT_DUTY_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              slot_begin_i,
    input  logic              slot_end_i,
    output logic [DUTY_W-1:0] slot_o,
    output logic              frame_start_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] slot;
    } slot_state_t;

    slot_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (slot_end_i) s_d.slot = s_q.slot + 1'b1;
        frame_start_o = slot_begin_i && (s_q.slot == '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign slot_o = s_q.slot;
endmodule

// File: rtl/pwm_duty_compare.sv
module pwm_duty_compare #(
    parameter int unsigned DUTY_W = pwm_pkg::DEFAULT_DUTY_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              frame_start_i,
    input  logic [DUTY_W-1:0] slot_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [DUTY_W-1:0] duty_lat_o,
    output logic              pwm_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic              pwm;
    } cmp_state_t;

    cmp_state_t s_d, s_q;
    logic [DUTY_W-1:0] eff_duty;

    always_comb begin
        s_d = s_q;
        eff_duty = frame_start_i ? duty_i : s_q.duty;
        s_d.duty = eff_duty;
        s_d.pwm  = (slot_i < eff_duty);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign duty_lat_o = s_q.duty;
    assign pwm_o      = s_q.pwm;
endmodule

// File: rtl/pwm_frame_gen.sv
module pwm_frame_gen #(
    parameter int unsigned TICKS_PER_SLOT = pwm_pkg::DEFAULT_TICKS,
    parameter int unsigned DUTY_W         = pwm_pkg::DEFAULT_DUTY_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);
    localparam int unsigned CW = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;

    logic              slot_begin;
    logic              slot_end;
    logic [CW-1:0]     tick_cnt;
    logic [DUTY_W-1:0] slot_idx;
    logic              frame_start;
    logic [DUTY_W-1:0] duty_lat;

    pwm_slot_prescaler #(.TICKS_PER_SLOT(TICKS_PER_SLOT)) u_pre (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .slot_begin_o(slot_begin),
        .slot_end_o  (slot_end),
        .tick_o      (tick_cnt)
    );

    pwm_slot_counter #(.DUTY_W(DUTY_W)) u_slot (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .slot_begin_i (slot_begin),
        .slot_end_i   (slot_end),
        .slot_o       (slot_idx),
        .frame_start_o(frame_start)
    );

    pwm_duty_compare #(.DUTY_W(DUTY_W)) u_cmp (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .frame_start_i(frame_start),
        .slot_i       (slot_idx),
        .duty_i       (duty_i),
        .duty_lat_o   (duty_lat),
        .pwm_o        (pwm_o)
    );
endmodule

// File: rtl/pwm_frame_chk.sv
module pwm_frame_chk #(
    parameter int unsigned TICKS_PER_SLOT = pwm_pkg::DEFAULT_TICKS,
    parameter int unsigned DUTY_W         = pwm_pkg::DEFAULT_DUTY_W
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              pwm_o,
    input logic              slot_end,
    input logic              frame_start,
    input logic [((TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1)-1:0] tick_cnt,
    input logic [DUTY_W-1:0] slot_idx,
    input logic [DUTY_W-1:0] duty_lat
);
    // R1
    reset_low_chk: assert property (@(posedge clk_i) rst_i |=> !pwm_o);

    // R2
    slot_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !slot_end |=> $stable(slot_idx));

    // R2
    slot_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        slot_end |=> (slot_idx == DUTY_W'($past(slot_idx) + 1'b1)));

    // R2
    tick_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        32'(tick_cnt) < TICKS_PER_SLOT);

    // R3
    past_duty_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!frame_start && (slot_idx >= duty_lat)) |=> !pwm_o);

    // R5
    last_slot_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (slot_idx == {DUTY_W{1'b1}}) |=> !pwm_o);

    // R6
    duty_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_start |=> $stable(duty_lat));
endmodule

bind pwm_frame_gen pwm_frame_chk #(
    .TICKS_PER_SLOT(TICKS_PER_SLOT),
    .DUTY_W        (DUTY_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pwm_o      (pwm_o),
    .slot_end   (slot_end),
    .frame_start(frame_start),
    .tick_cnt   (tick_cnt),
    .slot_idx   (slot_idx),
    .duty_lat   (duty_lat)
);

// File: tb/test_pwm_frame_gen.sv
`timescale 1ns/1ps
module test_pwm_frame_gen;
    localparam int T     = 3;
    localparam int W     = 8;
    localparam int SLOTS = 1 << W;
    localparam int FRAME = SLOTS * T;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] din = '0;
    logic pwm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int n = 0;
    logic [W-1:0] lat = '0;
    logic exp_pwm = 1'b0;
    int highs = 0;

    always #2.5 clk = ~clk;

    pwm_frame_gen #(.TICKS_PER_SLOT(T), .DUTY_W(W)) i_pwm_frame_gen (
        .clk_i (clk),
        .rst_i (rst),
        .duty_i(din),
        .pwm_o (pwm)
    );

    function automatic logic model_out(int idx, logic [W-1:0] d);
        return (((idx / T) % SLOTS) < int'(d));
    endfunction

    task automatic check(string tag, logic act, logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s cycle %0d: pwm=%0b expected %0b", tag, n, act, expv);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        if (rst) begin
            n = 0; lat = '0; exp_pwm = 1'b0;
        end else begin
            if (n % FRAME == 0) lat = din;
            exp_pwm = model_out(n, lat);
            n++;
        end
        @(negedge clk);
        if (pwm === 1'b1) highs++;
        check(tag, pwm, exp_pwm);
    endtask

    task automatic run_frame(string tag, logic [W-1:0] d, bit jitter);
        din = d;
        highs = 0;
        for (int i = 0; i < FRAME; i++) begin
            step(tag);
            if (jitter) din = W'($urandom);
        end
        n_checks++;
        if (highs != int'(d) * T) begin
            n_fail++;
            $display("FAIL %s high cycles=%0d expected %0d", tag, highs, int'(d) * T);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        for (int i = 0; i < 5; i++) step("R1");
        rst = 1'b0;
        run_frame("R4", 8'd0, 1'b0);
        run_frame("R5", 8'd255, 1'b0);
        run_frame("R3", 8'd1, 1'b0);
        run_frame("R3", 8'd128, 1'b0);
        for (int f = 0; f < 6; f++) run_frame("R2", W'($urandom), 1'b0);
        for (int f = 0; f < 6; f++) run_frame("R6", W'($urandom), 1'b1);
        din = 8'd200;
        for (int i = 0; i < 100; i++) step("R6");
        din = 8'd3;
        for (int i = 100; i < FRAME; i++) step("R6");
        run_frame("R6", 8'd3, 1'b0);
        din = 8'd90;
        for (int i = 0; i < 200; i++) step("R3");
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step("R1");
        rst = 1'b0;
        run_frame("R7", 8'd10, 1'b0);
        run_frame("R7", 8'd254, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule